// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block is the digital sequencer for an eight-input successive-approximation converter. Software programs a channel range, a sampling window, a trigger source and a scan mode through a three-word register bus. The block then waits for a trigger, drives the converter core through the channels of the range with a sample / start / done handshake, stores each result and raises completion and overwrite flags, which can also drive an interrupt line.

Software starts a conversion by writing the run bit. With a timer or pin trigger, the same write only arms the block, and the trigger event starts the scan. In one-shot mode each channel of the range is converted once and the run bit then drops by itself. In continuous mode the scan wraps back to the first channel until software clears the run bit or the global enable. Channel numbers count upward modulo 8, so a range whose first channel is above its last wraps through channel 7 to channel 0.

Top module: `adc_scan_ctrl`

## Requirements
- R1: One-shot mode (config bit 6 = 0) converts each channel from the first channel (config [10:8]) up to the last channel (config [14:12]) exactly once, counting upward modulo 8. Busy then drops and the run bit (control bit 1) reads 0, so further triggers start nothing.
- R2: Continuous mode (config bit 6 = 1) wraps from the last channel back to the first and keeps converting until the run bit is written 0.
- R3: The trigger source field (config [5:4]) selects 0 = software (writing run=1 starts the scan at once), 1 = one-cycle timer underflow pulse, 2 = reserved (never starts a scan), 3 = falling edge of the active-low trigger pin after synchronisation. Under sources 1 and 3, writing run=1 only arms the block, the other source's event is ignored, and a rising pin edge starts nothing.
- R4: Sampling-time code c (config [2:0], reset value 7) holds the sample enable high for exactly c+2 clock cycles. A one-cycle start pulse follows in the next cycle.
- R5: The channel indicator (control [14:12]) equals the channel on the core channel output, resets to 0, and holds the last converted channel when idle.
- R6: The busy bit (control bit 10) reads 1 from the cycle after a scan starts until the scan ends or is aborted, and 0 otherwise.
- R7: Each result is stored in the data word [9:0] and sets the completion flag (control bit 8). A read of the data word clears the flag.
- R8: The overwrite flag (control bit 9) is set when a result is stored while the completion flag is still 1. Writing 1 to bit 9 clears it.
- R9: The interrupt output equals (completion flag AND enable bit 4) OR (overwrite flag AND enable bit 5).
- R10: Writing the control word with run=0 or enable (bit 0) = 0 during a conversion aborts it. Busy reads 0 immediately, and neither a result nor a flag is stored.
- R11: Triggers that arrive while busy are ignored, and nothing starts while the global enable bit is 0.
- R12: After reset the control word reads 0x0000, the config word reads 0x0007, the data word reads 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word select: 0 control/status, 1 config, 2 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only; read data follows bus_addr) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| trig_n | input | 1 | Active-low external trigger pin, asynchronous |
| tmr_uf | input | 1 | Timer underflow pulse, one cycle |
| core_ch | output | 3 | Channel selected at the converter core |
| core_sample | output | 1 | Sampling window enable |
| core_start | output | 1 | One-cycle conversion start |
| core_done | input | 1 | One-cycle conversion finished |
| core_result | input | RES_W | Conversion result, valid with core_done |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench goes after the channel walk across a wrapping range in continuous mode. A sequencer that compared channels without modulo-8 wrap, or that restarted at channel 0, would log a wrong channel order. It counts sample-enable cycles for several codes, which catches an off-by-one window. It also fires second triggers during a scan, reserved-source events and rising pin edges: a design that restarted or started on these would log extra conversions. An abort placed between start and done catches a design that still stores the late result, and scans left unread catch a completion flag that fails to clear on the data read or an overwrite flag that never sets.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   localparam int unsigned CH_W  = 3;
   localparam int unsigned SMP_W = 3;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_CFG  = 2'd1;
   localparam logic [1:0] ADR_DATA = 2'd2;

   // control/status word bit positions
   localparam int unsigned B_EN    = 0;
   localparam int unsigned B_RUN   = 1;
   localparam int unsigned B_DIE   = 4;
   localparam int unsigned B_OIE   = 5;
   localparam int unsigned B_DONE  = 8;
   localparam int unsigned B_OVR   = 9;
   localparam int unsigned B_BUSY  = 10;
   localparam int unsigned B_CH_LO = 12;

   // config word bit positions
   localparam int unsigned B_SMP_LO  = 0;
   localparam int unsigned B_SRC_LO  = 4;
   localparam int unsigned B_CONT    = 6;
   localparam int unsigned B_FRST_LO = 8;
   localparam int unsigned B_LAST_LO = 12;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SAMP = 2'd1,
      ST_STRT = 2'd2,
      ST_WAIT = 2'd3
   } scan_st_t;

   typedef enum logic [1:0] {
      TRG_SW  = 2'd0,
      TRG_TMR = 2'd1,
      TRG_RSV = 2'd2,
      TRG_EXT = 2'd3
   } trig_src_t;

   typedef struct packed {
      logic            cont;
      logic [CH_W-1:0] first;
      logic [CH_W-1:0] last;
      logic [SMP_W-1:0] smp_code;
      trig_src_t       src;
   } scan_cfg_t;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
   import adc_scan_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  trig_src_t src,
   input  logic      trig_n,
   input  logic      tmr_uf,
   output logic      hw_trig
);

   logic pin_s;
   logic pin_d;
   logic pin_fall;

   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("adc_trig_sel: SYNC_STAGES must be 0..4");
      end
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = trig_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sq <= '1;
            end else begin
               sq[0] <= trig_n;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sq[i] <= sq[i-1];
               end
            end
         end
         assign pin_s = sq[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d <= 1'b1;
      else        pin_d <= pin_s;
   end

   assign pin_fall = pin_d & ~pin_s;

   always_comb begin
      unique case (src)
         TRG_TMR: hw_trig = tmr_uf;
         TRG_EXT: hw_trig = pin_fall;
         default: hw_trig = 1'b0;
      endcase
   end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
   import adc_scan_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             cont,
   input  logic [CH_W-1:0]  first,
   input  logic [CH_W-1:0]  last,
   input  logic [SMP_W-1:0] smp_code,
   input  logic             core_done,
   output logic [CH_W-1:0]  cur_ch,
   output logic             core_sample,
   output logic             core_start,
   output logic             busy,
   output logic             store,
   output logic             scan_end
);

   localparam int unsigned CNT_W = $clog2((1 << SMP_W) + 2);

   scan_st_t         st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] smp_len;
   logic             at_last;

   assign smp_len  = CNT_W'(smp_code) + CNT_W'(2);
   assign at_last  = (cur_ch == last);
   assign busy     = (st != ST_IDLE);
   assign core_sample = (st == ST_SAMP);
   assign core_start  = (st == ST_STRT);
   assign store    = (st == ST_WAIT) && core_done && !abort;
   assign scan_end = store && at_last && !cont;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         cur_ch <= '0;
      end else if (abort) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_SAMP;
                  cur_ch <= first;
                  cnt    <= '0;
               end
            end
            ST_SAMP: begin
               if (cnt == smp_len - CNT_W'(1)) begin
                  st  <= ST_STRT;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            ST_STRT: st <= ST_WAIT;
            ST_WAIT: begin
               if (core_done) begin
                  if (at_last && !cont) begin
                     st <= ST_IDLE;
                  end else begin
                     st     <= ST_SAMP;
                     cnt    <= '0;
                     cur_ch <= at_last ? first : cur_ch + CH_W'(1);
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // window length observed at the core side
   logic [CNT_W-1:0] smp_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           smp_seen <= '0;
      else if (core_sample) smp_seen <= smp_seen + CNT_W'(1);
      else                  smp_seen <= '0;
   end

   AST_SMP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> (smp_seen == smp_len)); // R4
   AST_START_AFTER_SMP: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> $past(core_sample)); // R4
   AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      scan_end |=> !busy); // R1
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !core_sample)); // R10

endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
   import adc_scan_pkg::*;
#(
   parameter int unsigned RES_W  = 10,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              hw_trig,
   input  logic              busy,
   input  logic              store,
   input  logic              scan_end,
   input  logic [CH_W-1:0]   cur_ch,
   input  logic [RES_W-1:0]  result,
   output scan_cfg_t         cfg,
   output logic              start,
   output logic              abort,
   output logic              irq
);

   logic             en_q, run_q, die_q, oie_q, done_q, ovr_q;
   logic [RES_W-1:0] data_q;
   logic             ctrl_wr, cfg_wr, data_rd;
   logic             w_en, w_run;

   assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
   assign cfg_wr  = bus_wr && (bus_addr == ADR_CFG);
   assign data_rd = bus_rd && (bus_addr == ADR_DATA);
   assign w_en    = bus_wdata[B_EN];
   assign w_run   = bus_wdata[B_RUN];

   assign start = !busy && ((ctrl_wr && w_en && w_run && cfg.src == TRG_SW) ||
                            (run_q && en_q && hw_trig));
   assign abort = ctrl_wr && !(w_en && w_run);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         run_q <= 1'b0;
         die_q <= 1'b0;
         oie_q <= 1'b0;
      end else if (ctrl_wr) begin
         en_q  <= w_en;
         run_q <= w_en && w_run;
         die_q <= bus_wdata[B_DIE];
         oie_q <= bus_wdata[B_OIE];
      end else if (scan_end) begin
         run_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.cont     <= 1'b0;
         cfg.first    <= '0;
         cfg.last     <= '0;
         cfg.smp_code <= '1;
         cfg.src      <= TRG_SW;
      end else if (cfg_wr) begin
         cfg.cont     <= bus_wdata[B_CONT];
         cfg.first    <= bus_wdata[B_FRST_LO +: CH_W];
         cfg.last     <= bus_wdata[B_LAST_LO +: CH_W];
         cfg.smp_code <= bus_wdata[B_SMP_LO +: SMP_W];
         cfg.src      <= trig_src_t'(bus_wdata[B_SRC_LO +: 2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         done_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (store) data_q <= result;

         if (store)        done_q <= 1'b1;
         else if (data_rd) done_q <= 1'b0;

         if (store && done_q)                   ovr_q <= 1'b1;
         else if (ctrl_wr && bus_wdata[B_OVR])  ovr_q <= 1'b0;
      end
   end

   assign irq = (done_q && die_q) || (ovr_q && oie_q);

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADR_CTRL: begin
            bus_rdata[B_EN]              = en_q;
            bus_rdata[B_RUN]             = run_q;
            bus_rdata[B_DIE]             = die_q;
            bus_rdata[B_OIE]             = oie_q;
            bus_rdata[B_DONE]            = done_q;
            bus_rdata[B_OVR]             = ovr_q;
            bus_rdata[B_BUSY]            = busy;
            bus_rdata[B_CH_LO +: CH_W]   = cur_ch;
         end
         ADR_CFG: begin
            bus_rdata[B_SMP_LO +: SMP_W] = cfg.smp_code;
            bus_rdata[B_SRC_LO +: 2]     = cfg.src;
            bus_rdata[B_CONT]            = cfg.cont;
            bus_rdata[B_FRST_LO +: CH_W] = cfg.first;
            bus_rdata[B_LAST_LO +: CH_W] = cfg.last;
         end
         ADR_DATA: bus_rdata[RES_W-1:0] = data_q;
         default:  bus_rdata = '0;
      endcase
   end

   AST_DONE_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> done_q); // R7
   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(done_q && store)); // R8
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && hw_trig && !abort) |=> busy); // R11

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int unsigned RES_W       = 10,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              trig_n,
   input  logic              tmr_uf,
   output logic [2:0]        core_ch,
   output logic              core_sample,
   output logic              core_start,
   input  logic              core_done,
   input  logic [RES_W-1:0]  core_result,
   output logic              irq
);

   generate
      if (DATA_W < B_LAST_LO + CH_W) begin : g_bad_dw
         $error("adc_scan_ctrl: DATA_W too narrow for the register fields");
      end
      if (RES_W < 1 || RES_W > DATA_W) begin : g_bad_rw
         $error("adc_scan_ctrl: RES_W must be 1..DATA_W");
      end
   endgenerate

   scan_cfg_t       cfg;
   logic            hw_trig, start, abort, busy, store, scan_end;
   logic [CH_W-1:0] cur_ch;

   adc_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (cfg.src),
      .trig_n  (trig_n),
      .tmr_uf  (tmr_uf),
      .hw_trig (hw_trig)
   );

   adc_scan_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .abort       (abort),
      .cont        (cfg.cont),
      .first       (cfg.first),
      .last        (cfg.last),
      .smp_code    (cfg.smp_code),
      .core_done   (core_done),
      .cur_ch      (cur_ch),
      .core_sample (core_sample),
      .core_start  (core_start),
      .busy        (busy),
      .store       (store),
      .scan_end    (scan_end)
   );

   adc_scan_regs #(.RES_W(RES_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .hw_trig   (hw_trig),
      .busy      (busy),
      .store     (store),
      .scan_end  (scan_end),
      .cur_ch    (cur_ch),
      .result    (core_result),
      .cfg       (cfg),
      .start     (start),
      .abort     (abort),
      .irq       (irq)
   );

   assign core_ch = cur_ch;

endmodule

// File: tb/sim_adc_scan_ctrl.sv
`timescale 1ns/1ps
module sim_adc_scan_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        trig_n = 1'b1;
   logic        tmr_uf = 1'b0;
   logic [2:0]  core_ch;
   logic        core_sample, core_start;
   logic        core_done = 1'b0;
   logic [9:0]  core_result = 10'd0;
   logic        irq;

   always #10 clk = ~clk;

   adc_scan_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_n(trig_n), .tmr_uf(tmr_uf),
      .core_ch(core_ch), .core_sample(core_sample), .core_start(core_start),
      .core_done(core_done), .core_result(core_result), .irq(irq)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int chlog[64];
   int nlog = 0;
   int smp_cur = 0;
   int last_smp = 0;
   int dn_cnt = 0;
   int cur_ch = 0;

   function automatic int res_of(int ch);
      return ch * 64 + ch + 1;
   endfunction

   // converter core model
   always @(negedge clk) begin
      if (core_done) core_done = 1'b0;
      if (dn_cnt > 0) begin
         dn_cnt--;
         if (dn_cnt == 0) begin
            core_done   = 1'b1;
            core_result = 10'(res_of(cur_ch));
         end
      end
      if (core_sample) smp_cur++;
      if (core_start) begin
         if (nlog < 64) chlog[nlog] = int'(core_ch);
         nlog++;
         last_smp = smp_cur;
         smp_cur  = 0;
         cur_ch   = int'(core_ch);
         dn_cnt   = 3;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ctrlw(int en, int run, int die, int oie, int oclr);
      return 16'(en | (run << 1) | (die << 4) | (oie << 5) | (oclr << 9));
   endfunction

   function automatic logic [15:0] cfgw(int code, int src, int cont, int first, int last);
      return 16'(code | (src << 4) | (cont << 6) | (first << 8) | (last << 12));
   endfunction

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output int v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = int'(bus_rdata);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(logic [1:0] a, output int v);
      bus_addr = a;
      #1 v = int'(bus_rdata);
   endtask

   task automatic wait_idle();
      int v;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         peek(2'd0, v);
         if (((v >> 10) & 1) == 0) return;
      end
   endtask

   task automatic busy_within(int n, output int b);
      int v;
      b = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         peek(2'd0, v);
         if (((v >> 10) & 1) == 1) b = 1;
      end
   endtask

   task automatic pulse_tmr();
      @(negedge clk); tmr_uf = 1'b1;
      @(negedge clk); tmr_uf = 1'b0;
   endtask

   task automatic clear_flags();
      int v;
      rd(2'd2, v);
      wr(2'd0, ctrlw(1, 0, 0, 0, 1));
   endtask

   task automatic t_reset();
      int v;
      rd(2'd0, v); chk("R12 ctrl reset", v, 0);
      chk("R5 channel indicator reset", (v >> 12) & 7, 0);
      chk("R6 busy reset", (v >> 10) & 1, 0);
      rd(2'd1, v); chk("R12 config reset (R4 code 7)", v, 7);
      rd(2'd2, v); chk("R12 data reset", v, 0);
      chk("R12 irq reset", int'(irq), 0);
      chk("R4 sample idle", int'(core_sample), 0);
   endtask

   task automatic t_oneshot();
      int v;
      wr(2'd1, cfgw(0, 0, 0, 2, 4));
      nlog = 0;
      wr(2'd0, ctrlw(1, 1, 0, 0, 0));
      peek(2'd0, v); chk("R6 busy after start", (v >> 10) & 1, 1);
      wait_idle();
      chk("R1 conversions", nlog, 3);
      chk("R1 ch0", chlog[0], 2); chk("R1 ch1", chlog[1], 3); chk("R1 ch2", chlog[2], 4);
      chk("R4 window code 0", last_smp, 2);
      rd(2'd0, v);
      chk("R1 run cleared", (v >> 1) & 1, 0);
      chk("R5 indicator holds last", (v >> 12) & 7, 4);
      chk("R7 done set", (v >> 8) & 1, 1);
      chk("R8 overwrite set", (v >> 9) & 1, 1);
      chk("R9 irq masked", int'(irq), 0);
      wr(2'd0, ctrlw(1, 0, 1, 0, 0));
      #1 chk("R9 irq from done", int'(irq), 1);
      rd(2'd2, v); chk("R7 data last result", v, res_of(4));
      rd(2'd0, v); chk("R7 done cleared by read", (v >> 8) & 1, 0);
      chk("R9 irq after done clear", int'(irq), 0);
      wr(2'd0, ctrlw(1, 0, 0, 1, 0));
      #1 chk("R9 irq from overwrite", int'(irq), 1);
      wr(2'd0, ctrlw(1, 0, 0, 1, 1));
      rd(2'd0, v); chk("R8 overwrite w1c", (v >> 9) & 1, 0);
      chk("R9 irq after w1c", int'(irq), 0);
   endtask

   task automatic t_window(int code);
      wr(2'd1, cfgw(code, 0, 0, 1, 1));
      nlog = 0;
      wr(2'd0, ctrlw(1, 1, 0, 0, 0));
      wait_idle();
      chk("R4 single conversion", nlog, 1);
      chk("R4 window length", last_smp, code + 2);
      clear_flags();
   endtask

   task automatic t_cont();
      int v;
      int exp_seq[6] = '{6, 7, 0, 1, 6, 7};
      wr(2'd1, cfgw(0, 0, 1, 6, 1));
      nlog = 0;
      wr(2'd0, ctrlw(1, 1, 0, 0, 0));
      for (int i = 0; i < 2000 && nlog < 6; i++) @(negedge clk);
      wr(2'd0, ctrlw(1, 0, 0, 0, 0));
      peek(2'd0, v); chk("R2 stop clears busy", (v >> 10) & 1, 0);
      for (int i = 0; i < 6; i++) chk("R2 wrap order", chlog[i], exp_seq[i]);
      clear_flags();
   endtask

   task automatic t_timer();
      int b;
      wr(2'd1, cfgw(1, 1, 0, 0, 1));
      nlog = 0;
      wr(2'd0, ctrlw(1, 1, 0, 0, 0));
      busy_within(5, b); chk("R3 timer source: write only arms", b, 0);
      pulse_tmr();
      busy_within(2, b); chk("R3 timer pulse starts", b, 1);
      pulse_tmr();
      wait_idle();
      chk("R11 trigger while busy ignored", nlog, 2);
      chk("R11 order ch0", chlog[0], 0); chk("R11 order ch1", chlog[1], 1);
      pulse_tmr();
      busy_within(5, b); chk("R1 no start after one-shot", b, 0);
      clear_flags();
   endtask

   task automatic t_ext();
      int b;
      wr(2'd1, cfgw(0, 3, 0, 5, 5));
      nlog = 0;
      wr(2'd0, ctrlw(1, 1, 0, 0, 0));
      pulse_tmr();
      busy_within(5, b); chk("R3 timer ignored under pin source", b, 0);
      @(negedge clk); trig_n = 1'b0;
      busy_within(8, b); chk("R3 pin falling edge starts", b, 1);
      wait_idle();
      chk("R3 pin scan channel", chlog[0], 5);
      chk("R3 pin scan count", nlog, 1);
      wr(2'd0, ctrlw(1, 1, 0, 0, 0));
      @(negedge clk); trig_n = 1'b1;
      busy_within(8, b); chk("R3 rising edge ignored", b, 0);
      wr(2'd0, ctrlw(1, 0, 0, 0, 0));
      clear_flags();
   endtask

   task automatic t_rsv();
      int b;
      wr(2'd1, cfgw(0, 2, 0, 0, 0));
      nlog = 0;
      wr(2'd0, ctrlw(1, 1, 0, 0, 0));
      pulse_tmr();
      @(negedge clk); trig_n = 1'b0;
      busy_within(8, b); chk("R3 reserved source never starts", b, 0);
      chk("R3 reserved no conversion", nlog, 0);
      trig_n = 1'b1;
      wr(2'd0, ctrlw(1, 0, 0, 0, 0));
   endtask

   task automatic t_disabled();
      int b;
      wr(2'd1, cfgw(0, 0, 0, 0, 0));
      nlog = 0;
      wr(2'd0, ctrlw(0, 1, 0, 0, 0));
      busy_within(6, b); chk("R11 disabled no start", b, 0);
      chk("R11 disabled no conversion", nlog, 0);
   endtask

   task automatic t_abort();
      int v, prev;
      clear_flags();
      rd(2'd2, prev);
      wr(2'd1, cfgw(7, 0, 0, 3, 3));
      nlog = 0;
      wr(2'd0, ctrlw(1, 1, 0, 0, 0));
      for (int i = 0; i < 100 && nlog == 0; i++) @(negedge clk);
      wr(2'd0, ctrlw(1, 0, 0, 0, 0));
      peek(2'd0, v); chk("R10 abort clears busy", (v >> 10) & 1, 0);
      repeat (8) @(negedge clk);
      rd(2'd0, v); chk("R10 abort no done flag", (v >> 8) & 1, 0);
      rd(2'd2, v); chk("R10 abort keeps data", v, prev);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_oneshot();
      t_window(3);
      t_window(7);
      t_cont();
      t_timer();
      t_ext();
      t_rsv();
      t_disabled();
      t_abort();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule